// File: doc/BRIEF.md
# Segment Selector Descriptor Checker

This block turns a 16-bit segment selector into the linear address of its descriptor entry and decides whether that entry may be fetched. The selector's table-indicator bit picks either the local descriptor table or the global descriptor table. The byte offset of the entry is the selector index times eight. That offset is added to the chosen table's base to form the descriptor address.

The offset, plus the access size, is then compared against the chosen table's limit. An entry that runs past the limit raises a general-protection fault. So does any use of the local table while the local table register holds a zero selector. The fault carries the incoming selector as its error code.

The block also reports a null selector through the zero flag and the extended zero flag. Only the flag bits named by an enable mask are touched. The check is registered: a start pulse captures every input, and all results are presented together with a done pulse one cycle later. The results then hold until the next start. Reading the descriptor itself is left to the consumer, which must give the fault priority over the address.

Top module: `seg_desc_checker`

## Requirements
- R1: Selector bit 2 selects the table. When it is 1, the local base and local limit are used. When it is 0, the global base and global limit are used.
- R2: The descriptor address is the chosen base plus selector bits [15:3] times eight, modulo 2^ADDR_W. It is driven whether or not a fault is raised.
- R3: A fault is raised when index*8 + size, computed without wrap, is greater than the chosen limit. When the sum equals the limit, no fault is raised.
- R4: When bit 2 is 1 and the local table register selector is zero, a fault is raised regardless of the limit comparison.
- R5: The error code equals the selector captured at start, all 16 bits.
- R6: A selector whose bits [15:2] are all zero is null. For each of flag bits 6 (zero flag) and 7 (extended zero flag) where the mask bit is 1, the output bit is 1 for a null selector and 0 otherwise.
- R7: Every other flag output bit equals the captured input flag bit. This covers bits other than 6 and 7, and bits 6 or 7 whose mask bit is 0.
- R8: done_o is 1 exactly in the cycle after a cycle with start_i high. All results change only on a start, and inputs presented without start_i have no effect.
- R9: After reset, done_o, fault_o, desc_addr_o, err_code_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Capture inputs and begin a check |
| sel_i | input | 16 | Segment selector: RPL [1:0], table indicator [2], index [15:3] |
| size_i | input | SIZE_W | Access size in bytes |
| lt_base_i | input | ADDR_W | Local table base |
| lt_limit_i | input | LIM_W | Local table limit |
| lt_sel_i | input | 16 | Selector held in the local table register |
| gt_base_i | input | ADDR_W | Global table base |
| gt_limit_i | input | LIM_W | Global table limit |
| flag_mask_i | input | FLAG_W | Flag update enable mask |
| flags_i | input | FLAG_W | Current flag bits |
| done_o | output | 1 | Results valid pulse |
| desc_addr_o | output | ADDR_W | Descriptor linear address |
| fault_o | output | 1 | General-protection fault |
| err_code_o | output | 16 | Fault error code |
| flags_o | output | FLAG_W | Updated flag bits |

## Verification
Every result is due in the cycle after the one in which start_i is sampled high. The address, fault, error code and flags come from the captured inputs through logic only, and done_o rises at that same edge. The bench drives start at a falling edge and samples all outputs at the next falling edge, when done_o must be 1. It then changes every input without start and samples again one cycle later. At that point done_o must be 0 and the earlier results must be unchanged.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = 13;
  localparam int TI_BIT  = 2;
  localparam int OFF_W   = 16;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LIM_W  = 32
) (
  input  logic [IDX_W-1:0]  index_i,
  input  logic              ti_i,
  input  logic [ADDR_W-1:0] lt_base_i,
  input  logic [LIM_W-1:0]  lt_limit_i,
  input  logic [SEL_W-1:0]  lt_sel_i,
  input  logic [ADDR_W-1:0] gt_base_i,
  input  logic [LIM_W-1:0]  gt_limit_i,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [LIM_W-1:0]  tbl_limit_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              ldt_null_o,
  output logic              sel_null_o
);
  always_comb begin
    tbl_base_o  = ti_i ? lt_base_i  : gt_base_i;
    tbl_limit_o = ti_i ? lt_limit_i : gt_limit_i;
    offset_o    = {index_i, 3'b000};
    ldt_null_o  = ti_i && (lt_sel_i == '0);
    sel_null_o  = !ti_i && (index_i == '0);
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LIM_W  = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              ldt_null_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  localparam int MAX_A = (LIM_W > OFF_W) ? LIM_W : OFF_W;
  localparam int MAX_W = (MAX_A > SIZE_W) ? MAX_A : SIZE_W;
  localparam int CMP_W = MAX_W + 1;

  logic [CMP_W-1:0] end_off;
  logic             over;

  always_comb begin
    end_off = CMP_W'(offset_i) + CMP_W'(size_i);
    over    = end_off > CMP_W'(limit_i);
    fault_o = ldt_null_i || over;
    addr_o  = base_i + ADDR_W'(offset_i);
  end
endmodule

// File: rtl/seg_flag_merge.sv
module seg_flag_merge #(
  parameter int FLAG_W  = 8,
  parameter int ZF_POS  = 6,
  parameter int EZF_POS = 7
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic              sel_null_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (b == ZF_POS || b == EZF_POS) begin : g_zero
      assign flags_o[b] = mask_i[b] ? sel_null_i : flags_i[b];
    end else begin : g_keep
      assign flags_o[b] = flags_i[b];
    end
  end
endmodule

// File: rtl/seg_desc_checker.sv
module seg_desc_checker
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LIM_W   = 32,
  parameter int SIZE_W  = 4,
  parameter int FLAG_W  = 8,
  parameter int ZF_POS  = 6,
  parameter int EZF_POS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       sel_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] lt_base_i,
  input  logic [LIM_W-1:0]  lt_limit_i,
  input  logic [15:0]       lt_sel_i,
  input  logic [ADDR_W-1:0] gt_base_i,
  input  logic [LIM_W-1:0]  gt_limit_i,
  input  logic [FLAG_W-1:0] flag_mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic              fault_o,
  output logic [15:0]       err_code_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic rst_n_sync;

  seg_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_sync));

  // captured operands
  logic [SEL_W-1:0]  sel_q,   sel_d;
  logic [SIZE_W-1:0] size_q,  size_d;
  logic [ADDR_W-1:0] ltb_q,   ltb_d;
  logic [LIM_W-1:0]  ltl_q,   ltl_d;
  logic [SEL_W-1:0]  lts_q,   lts_d;
  logic [ADDR_W-1:0] gtb_q,   gtb_d;
  logic [LIM_W-1:0]  gtl_q,   gtl_d;
  logic [FLAG_W-1:0] mask_q,  mask_d;
  logic [FLAG_W-1:0] flg_q,   flg_d;
  logic              done_q,  done_d;

  always_comb begin
    sel_d  = sel_q;
    size_d = size_q;
    ltb_d  = ltb_q;
    ltl_d  = ltl_q;
    lts_d  = lts_q;
    gtb_d  = gtb_q;
    gtl_d  = gtl_q;
    mask_d = mask_q;
    flg_d  = flg_q;
    done_d = start_i;
    if (start_i) begin
      sel_d  = sel_i;
      size_d = size_i;
      ltb_d  = lt_base_i;
      ltl_d  = lt_limit_i;
      lts_d  = lt_sel_i;
      gtb_d  = gt_base_i;
      gtl_d  = gt_limit_i;
      mask_d = flag_mask_i;
      flg_d  = flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      sel_q  <= '0;
      size_q <= '0;
      ltb_q  <= '0;
      ltl_q  <= '0;
      lts_q  <= '0;
      gtb_q  <= '0;
      gtl_q  <= '0;
      mask_q <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      size_q <= size_d;
      ltb_q  <= ltb_d;
      ltl_q  <= ltl_d;
      lts_q  <= lts_d;
      gtb_q  <= gtb_d;
      gtl_q  <= gtl_d;
      mask_q <= mask_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  logic [ADDR_W-1:0] tbl_base;
  logic [LIM_W-1:0]  tbl_limit;
  logic [OFF_W-1:0]  offset;
  logic              ldt_null;
  logic              sel_null;

  seg_sel_decode #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_dec (
    .index_i    (sel_q[SEL_W-1:3]),
    .ti_i       (sel_q[TI_BIT]),
    .lt_base_i  (ltb_q),
    .lt_limit_i (ltl_q),
    .lt_sel_i   (lts_q),
    .gt_base_i  (gtb_q),
    .gt_limit_i (gtl_q),
    .tbl_base_o (tbl_base),
    .tbl_limit_o(tbl_limit),
    .offset_o   (offset),
    .ldt_null_o (ldt_null),
    .sel_null_o (sel_null)
  );

  seg_limit_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W)) u_lim (
    .base_i    (tbl_base),
    .limit_i   (tbl_limit),
    .offset_i  (offset),
    .size_i    (size_q),
    .ldt_null_i(ldt_null),
    .addr_o    (desc_addr_o),
    .fault_o   (fault_o)
  );

  seg_flag_merge #(.FLAG_W(FLAG_W), .ZF_POS(ZF_POS), .EZF_POS(EZF_POS)) u_flg (
    .flags_i   (flg_q),
    .mask_i    (mask_q),
    .sel_null_i(sel_null),
    .flags_o   (flags_o)
  );

  assign done_o     = done_q;
  assign err_code_o = sel_q;
endmodule

// File: rtl/seg_desc_checker_sva.sv
module seg_desc_checker_sva #(
  parameter int ADDR_W  = 64,
  parameter int FLAG_W  = 8,
  parameter int ZF_POS  = 6,
  parameter int EZF_POS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [15:0]       sel_i,
  input logic [15:0]       lt_sel_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              done_o,
  input logic              fault_o,
  input logic [15:0]       err_code_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [ADDR_W-1:0] desc_addr_o
);
  localparam logic [FLAG_W-1:0] ZMASK =
    (FLAG_W'(1) << ZF_POS) | (FLAG_W'(1) << EZF_POS);

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));

  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(desc_addr_o) && $stable(fault_o) && $stable(flags_o)));

  a_r4_null_ldt_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && sel_i[2] && lt_sel_i == 16'h0) |=> fault_o);

  a_r5_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o) |-> (err_code_o == $past(sel_i)));

  a_r7_other_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (((flags_o ^ $past(flags_i)) & ~ZMASK) == '0));
endmodule

bind seg_desc_checker seg_desc_checker_sva #(
  .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .ZF_POS(ZF_POS), .EZF_POS(EZF_POS)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .start_i    (start_i),
  .sel_i      (sel_i),
  .lt_sel_i   (lt_sel_i),
  .flags_i    (flags_i),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .err_code_o (err_code_o),
  .flags_o    (flags_o),
  .desc_addr_o(desc_addr_o)
);

// File: tb/tb_seg_desc_checker.sv
module tb_seg_desc_checker;
  localparam int ADDR_W = 64;
  localparam int LIM_W  = 32;
  localparam int SIZE_W = 4;
  localparam int FLAG_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [15:0]       sel_i = '0;
  logic [SIZE_W-1:0] size_i = '0;
  logic [ADDR_W-1:0] lt_base_i = '0;
  logic [LIM_W-1:0]  lt_limit_i = '0;
  logic [15:0]       lt_sel_i = '0;
  logic [ADDR_W-1:0] gt_base_i = '0;
  logic [LIM_W-1:0]  gt_limit_i = '0;
  logic [FLAG_W-1:0] flag_mask_i = '0;
  logic [FLAG_W-1:0] flags_i = '0;
  logic              done_o;
  logic [ADDR_W-1:0] desc_addr_o;
  logic              fault_o;
  logic [15:0]       err_code_o;
  logic [FLAG_W-1:0] flags_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  seg_desc_checker dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input logic [15:0] s, input logic [63:0] lb, input logic [63:0] gb);
    return (s[2] ? lb : gb) + {48'h0, s[15:3], 3'b000};
  endfunction

  function automatic logic exp_fault(input logic [15:0] s, input logic [3:0] sz,
                                     input logic [31:0] ll, input logic [15:0] ls, input logic [31:0] gl);
    logic [33:0] e;
    e = {18'h0, s[15:3], 3'b000} + {30'h0, sz};
    if (s[2] && ls == 16'h0) return 1'b1;
    return e > {2'b00, (s[2] ? ll : gl)};
  endfunction

  function automatic logic [7:0] exp_flags(input logic [15:0] s, input logic [7:0] m, input logic [7:0] f);
    logic [7:0] r;
    logic nul;
    nul = (s[15:2] == 14'h0);
    r = f;
    if (m[6]) r[6] = nul;
    if (m[7]) r[7] = nul;
    return r;
  endfunction

  task automatic run_case(input logic [15:0] s, input logic [3:0] sz,
                          input logic [63:0] lb, input logic [31:0] ll, input logic [15:0] ls,
                          input logic [63:0] gb, input logic [31:0] gl,
                          input logic [7:0] m, input logic [7:0] f);
    logic [63:0] ea;
    logic ef;
    logic [7:0] eflg;
    @(negedge clk);
    sel_i = s; size_i = sz; lt_base_i = lb; lt_limit_i = ll; lt_sel_i = ls;
    gt_base_i = gb; gt_limit_i = gl; flag_mask_i = m; flags_i = f; start_i = 1'b1;
    ea = exp_addr(s, lb, gb);
    ef = exp_fault(s, sz, ll, ls, gl);
    eflg = exp_flags(s, m, f);
    @(negedge clk);
    start_i = 1'b0;
    check("R8 done", {63'h0, done_o}, 64'h1);
    check(s[2] ? "R1/R2 local addr" : "R1/R2 global addr", desc_addr_o, ea);
    check((s[2] && ls == 0) ? "R4 fault" : "R3 fault", {63'h0, fault_o}, {63'h0, ef});
    check("R5 err code", {48'h0, err_code_o}, {48'h0, s});
    check("R6/R7 flags", {56'h0, flags_o}, {56'h0, eflg});
    // disturb inputs without start: R8 ignored
    sel_i = ~s; lt_base_i = ~lb; gt_base_i = ~gb; lt_limit_i = '0; gt_limit_i = '0;
    flags_i = ~f; flag_mask_i = ~m; lt_sel_i = ~ls;
    @(negedge clk);
    check("R8 done drop", {63'h0, done_o}, 64'h0);
    check("R8 addr held", desc_addr_o, ea);
    check("R8 fault held", {63'h0, fault_o}, {63'h0, ef});
    check("R8 flags held", {56'h0, flags_o}, {56'h0, eflg});
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 done", {63'h0, done_o}, 64'h0);
    check("R9 fault", {63'h0, fault_o}, 64'h0);
    check("R9 addr", desc_addr_o, 64'h0);
    check("R9 err", {48'h0, err_code_o}, 64'h0);
    check("R9 flags", {56'h0, flags_o}, 64'h0);

    // directed corners
    run_case(16'h0003, 4'd8, 64'h1000, 32'hFFFF, 16'h0028, 64'h2000, 32'h00FF, 8'hFF, 8'h00); // R6 null
    run_case(16'h0000, 4'd8, 64'h1000, 32'hFFFF, 16'h0028, 64'h2000, 32'h00FF, 8'h00, 8'h3C); // R7 mask off
    run_case(16'h0010, 4'd8, 64'h1000, 32'hFFFF, 16'h0028, 64'h2000, 32'h00FF, 8'hC0, 8'hFF); // R6 non-null clears
    run_case(16'h000C, 4'd8, 64'h5000, 32'hFFFF, 16'h0000, 64'h2000, 32'hFFFF, 8'h40, 8'h00); // R4
    run_case(16'h0078, 4'd8, 64'h0, 32'h0, 16'h0010, 64'hA000, 32'h0080, 8'h00, 8'h00);       // R3 equal
    run_case(16'h0078, 4'd9, 64'h0, 32'h0, 16'h0010, 64'hA000, 32'h0080, 8'h00, 8'h00);       // R3 over
    run_case(16'h007C, 4'd8, 64'h3000, 32'h0080, 16'h0010, 64'h0, 32'h0, 8'h00, 8'h00);       // R1 local equal
    run_case(16'hFFFC, 4'd15, 64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_FFFF, 16'h0001, 64'h0, 32'h0, 8'hFF, 8'h55); // R2 wrap

    // random
    for (int i = 0; i < 300; i++) begin
      logic [15:0] rs, rls;
      logic [31:0] rll, rgl;
      rs  = $urandom();
      if ($urandom_range(0, 7) == 0) rs[15:3] = '0;
      rls = ($urandom_range(0, 5) == 0) ? 16'h0 : 16'($urandom());
      rll = $urandom_range(0, 3) == 0 ? $urandom() : 32'($urandom_range(0, 65535));
      rgl = $urandom_range(0, 3) == 0 ? $urandom() : 32'($urandom_range(0, 65535));
      run_case(rs, 4'($urandom()), {$urandom(), $urandom()}, rll, rls,
               {$urandom(), $urandom()}, rgl, 8'($urandom()), 8'($urandom()));
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule